// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block turns a functional clock into the serial clock waveform of an I2C master. A prescaler divides the functional clock by (prescale + 1) to form an internal sampling tick. Each bit then spends a programmable number of ticks with SCL driven low, followed by a programmable number of ticks with SCL released high. The low count is the low field plus 7 and the high count is the high field plus 5. Each timing word is 16 bits wide. Its low byte holds the count for standard and fast mode. Its high byte holds the count for high-speed mode, and that byte is used only while the high-speed select is set.

The bit engine that owns START, STOP and data sequencing raises `run` to request bits. The generator tells it where to act through two one-cycle strobes. `drive_stb` marks the first clock of every low phase, which is where the next data level is set up. `sample_stb` marks the middle of every high phase, which is where the line is read. The control is a three-state machine. ST_IDLE goes to ST_LOW on a start, when the block is enabled and `run` is high. ST_LOW goes to ST_HIGH when the low count expires. ST_HIGH goes back to ST_LOW when the high count expires with `run` still high, and to ST_IDLE when it expires with `run` low. Clearing `enable` forces ST_IDLE from any state. The prescale value and the selected counts are captured only on the ST_IDLE to ST_LOW start and then stay fixed for the whole burst.

Top module: `scl_rate_gen`

## Requirements
- R1: While `enable` is low, `scl_o` is 1 and `samp_tick`, `drive_stb` and `sample_stb` are 0 from the next clock. A bit aborted by disable leaves no residue: the next start produces a complete, correctly timed bit.
- R2: While a bit is in progress, `samp_tick` pulses for one clock every (PSC+1) clocks, where PSC is `psc_val`. The low phase therefore contains exactly (low count) ticks. While idle, `samp_tick` stays 0.
- R3: In standard/fast mode (`hs_sel`=0), `scl_o` stays 0 for (`scll_word[7:0]`+7)×(PSC+1) clocks per bit.
- R4: In standard/fast mode, `scl_o` stays 1 for (`sclh_word[7:0]`+5)×(PSC+1) clocks per bit. This is measured up to and including the last tick of the phase.
- R5: With `hs_sel`=1 at the start, `scll_word[15:8]` replaces the low byte in R3 and `sclh_word[15:8]` replaces it in R4.
- R6: `drive_stb` is high for exactly one clock per bit. That clock is the first clock in which `scl_o` is 0.
- R7: `sample_stb` is high for exactly one clock per bit. It comes floor(H/2)×(PSC+1) clocks after the first high clock, where H is the high count of R4 or R5.
- R8: If `enable` and `run` are 1 at a clock edge while idle, `scl_o` is 0 from that edge. If `run` is still 1 at the edge that ends a high phase, the next bit follows without a gap. Otherwise the generator goes idle, and no bits are produced beyond those requested.
- R9: The timing inputs are captured only at the start. Changes made during a burst have no effect until the next start.
- R10: A 48 MHz clock gives periods of 480, 120 and 48 clocks (100 kHz, 400 kHz, 1 MHz) with PSC=1 and low/high fields 111/117, 23/25 and 5/7. A 96 MHz clock gives periods of 960 and 240 clocks with PSC=23, 13/15 and PSC=9, 5/7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle, SCL released and counters at zero |
| psc_val | input | PSC_W (8) | Prescale value; the tick period is psc_val+1 clocks |
| scll_word | input | 2*CNT_W (16) | Low-phase field: [7:0] standard/fast, [15:8] high-speed |
| sclh_word | input | 2*CNT_W (16) | High-phase field: [7:0] standard/fast, [15:8] high-speed |
| hs_sel | input | 1 | Selects the high-speed byte of both words at start |
| run | input | 1 | Bit request from the bit engine |
| samp_tick | output | 1 | Internal sampling tick |
| scl_o | output | 1 | SCL level (0 drive low, 1 released) |
| drive_stb | output | 1 | One-cycle strobe at the start of each low phase |
| sample_stb | output | 1 | One-cycle strobe at the midpoint of each high phase |

## Verification
The bench uses the default parameters: 8-bit prescale and count fields, a 9-bit phase length, and offsets of 7 and 5. Every stated reference rate is therefore reachable, including a prescale of 23 and both byte lanes of the timing words. With these values, phase lengths of up to 262 ticks and tick periods of up to 256 clocks are in range. Bursts, high-speed selection, a mid-burst reprogram and a mid-bit disable are run through a scoreboard that compares each measured low length, high length and strobe position with values computed from the formulas.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;

endpackage

// File: rtl/scl_cfg_latch.sv
// Captures the prescale value and the selected phase lengths at each start.
module scl_cfg_latch #(
    parameter int PSC_W    = 8,
    parameter int CNT_W    = 8,
    parameter int LEN_W    = CNT_W + 1,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 load,
    input  logic                 hs_sel,
    input  logic [PSC_W-1:0]     psc_val,
    input  logic [2*CNT_W-1:0]   scll_word,
    input  logic [2*CNT_W-1:0]   sclh_word,
    output logic [PSC_W-1:0]     psc_q,
    output logic [LEN_W-1:0]     low_len_q,
    output logic [LEN_W-1:0]     high_len_q,
    output logic [LEN_W-1:0]     half_high_q
);

    logic [CNT_W-1:0] low_sel;
    logic [CNT_W-1:0] high_sel;
    logic [LEN_W-1:0] low_len_d;
    logic [LEN_W-1:0] high_len_d;

    // High-speed counts live in the upper byte lane of each word.
    always_comb begin
        low_sel    = hs_sel ? scll_word[2*CNT_W-1:CNT_W] : scll_word[CNT_W-1:0];
        high_sel   = hs_sel ? sclh_word[2*CNT_W-1:CNT_W] : sclh_word[CNT_W-1:0];
        low_len_d  = LEN_W'(low_sel)  + LEN_W'(LOW_OFS);
        high_len_d = LEN_W'(high_sel) + LEN_W'(HIGH_OFS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q       <= '0;
            low_len_q   <= '0;
            high_len_q  <= '0;
            half_high_q <= '0;
        end else if (!enable) begin
            psc_q       <= '0;
            low_len_q   <= '0;
            high_len_q  <= '0;
            half_high_q <= '0;
        end else if (load) begin
            psc_q       <= psc_val;
            low_len_q   <= low_len_d;
            high_len_q  <= high_len_d;
            half_high_q <= high_len_d >> 1;
        end
    end

endmodule

// File: rtl/scl_presc.sv
// Divides the functional clock by (psc_q + 1) into a one-cycle tick.
module scl_presc #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [PSC_W-1:0] psc_q,
    output logic             tick,
    output logic             at_zero
);

    logic [PSC_W-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!active) begin
            div_cnt <= '0;
        end else if (div_cnt == psc_q) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + PSC_W'(1);
        end
    end

    assign tick    = active && (div_cnt == psc_q);
    assign at_zero = (div_cnt == '0);

endmodule

// File: rtl/scl_phase_fsm.sv
// Idle / low / high sequencer with a tick counter per phase.
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output scl_state_e       state,
    output logic [LEN_W-1:0] ph_cnt,
    output logic             start
);

    scl_state_e       nxt;
    logic [LEN_W-1:0] cur_len;
    logic             phase_end;

    always_comb begin
        cur_len   = (state == ST_HIGH) ? high_len : low_len;
        phase_end = tick && (ph_cnt == (cur_len - LEN_W'(1)));
    end

    // Next-state logic
    always_comb begin
        nxt   = state;
        start = 1'b0;
        if (!enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run) begin
                        nxt   = ST_LOW;
                        start = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (phase_end) nxt = ST_HIGH;
                end
                ST_HIGH: begin
                    if (phase_end) nxt = run ? ST_LOW : ST_IDLE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register and phase tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph_cnt <= '0;
        end else begin
            state <= nxt;
            if (!enable || state == ST_IDLE || phase_end) begin
                ph_cnt <= '0;
            end else if (tick) begin
                ph_cnt <= ph_cnt + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/scl_rate_gen.sv
// SCL bit-rate generator top.
module scl_rate_gen
    import scl_pkg::*;
#(
    parameter int PSC_W    = 8,
    parameter int CNT_W    = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [PSC_W-1:0]   psc_val,
    input  logic [2*CNT_W-1:0] scll_word,
    input  logic [2*CNT_W-1:0] sclh_word,
    input  logic               hs_sel,
    input  logic               run,
    output logic               samp_tick,
    output logic               scl_o,
    output logic               drive_stb,
    output logic               sample_stb
);

    localparam int LEN_W = CNT_W + 1;

    scl_state_e       state;
    logic [LEN_W-1:0] ph_cnt;
    logic             start;
    logic [PSC_W-1:0] psc_q;
    logic [LEN_W-1:0] low_len_q;
    logic [LEN_W-1:0] high_len_q;
    logic [LEN_W-1:0] half_high_q;
    logic             tick;
    logic             at_zero;
    logic             presc_active;

    assign presc_active = enable && (state != ST_IDLE);

    scl_cfg_latch #(
        .PSC_W    (PSC_W),
        .CNT_W    (CNT_W),
        .LEN_W    (LEN_W),
        .LOW_OFS  (LOW_OFS),
        .HIGH_OFS (HIGH_OFS)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .load        (start),
        .hs_sel      (hs_sel),
        .psc_val     (psc_val),
        .scll_word   (scll_word),
        .sclh_word   (sclh_word),
        .psc_q       (psc_q),
        .low_len_q   (low_len_q),
        .high_len_q  (high_len_q),
        .half_high_q (half_high_q)
    );

    scl_presc #(
        .PSC_W (PSC_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (presc_active),
        .psc_q   (psc_q),
        .tick    (tick),
        .at_zero (at_zero)
    );

    scl_phase_fsm #(
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .run      (run),
        .tick     (tick),
        .low_len  (low_len_q),
        .high_len (high_len_q),
        .state    (state),
        .ph_cnt   (ph_cnt),
        .start    (start)
    );

    // Output decode
    always_comb begin
        samp_tick  = tick;
        scl_o      = (state != ST_LOW);
        drive_stb  = enable && (state == ST_LOW) && at_zero && (ph_cnt == '0);
        sample_stb = enable && (state == ST_HIGH) && at_zero && (ph_cnt == half_high_q);
    end

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic run,
    input logic scl_o,
    input logic samp_tick,
    input logic drive_stb,
    input logic sample_stb
);

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !samp_tick && !drive_stb && !sample_stb)); // R1

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || (scl_o && !run && !samp_tick && $past(scl_o) && !$past(samp_tick) && !$past(run)))
        |=> (!samp_tick || !scl_o || $past(enable))); // R2

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> ($past(samp_tick) || !$past(enable))); // R3

    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> ($past(enable) && ($past(run) || $past(samp_tick)))); // R8

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> drive_stb); // R6

    AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> !scl_o); // R6

    AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_o); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_stb && sample_stb)); // R6

endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .run        (run),
    .scl_o      (scl_o),
    .samp_tick  (samp_tick),
    .drive_stb  (drive_stb),
    .sample_stb (sample_stb)
);

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  psc_val = '0;
    logic [15:0] scll_word = '0;
    logic [15:0] sclh_word = '0;
    logic        hs_sel = 1'b0;
    logic        run = 1'b0;
    logic        samp_tick, scl_o, drive_stb, sample_stb;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        int    lo;
        int    hi;
        int    so;
        int    nt;
        int    refp;
        string lreq;
        string hreq;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_rate_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .psc_val    (psc_val),
        .scll_word  (scll_word),
        .sclh_word  (sclh_word),
        .hs_sel     (hs_sel),
        .run        (run),
        .samp_tick  (samp_tick),
        .scl_o      (scl_o),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Driver side: compute expected bit timing from the requirements
    task automatic push_exp(input int p, input int lf, input int hf, input int refp,
                            input string lreq, input string hreq);
        exp_t e;
        e.lo   = (lf + 7) * (p + 1);
        e.hi   = (hf + 5) * (p + 1);
        e.so   = ((hf + 5) / 2) * (p + 1);
        e.nt   = lf + 7;
        e.refp = refp;
        e.lreq = lreq;
        e.hreq = hreq;
        exp_q.push_back(e);
    endtask

    task automatic one_bit(input int p, input int lw, input int hw, input bit hs, input int refp);
        int lf, hf;
        @(negedge clk);
        psc_val   = 8'(p);
        scll_word = 16'(lw);
        sclh_word = 16'(hw);
        hs_sel    = hs;
        run       = 1'b1;
        lf = hs ? (lw >> 8) & 255 : lw & 255;
        hf = hs ? (hw >> 8) & 255 : hw & 255;
        push_exp(p, lf, hf, refp, hs ? "R5" : "R3", hs ? "R5" : "R4");
        @(negedge clk);
        run = 1'b0;
        chk(scl_o == 1'b0, "R8 start latency", int'(scl_o), 0);
        repeat ((lf + hf + 12) * (p + 1) + 700) @(negedge clk);
    endtask

    // Monitor: measures each bit and compares against the queue
    bit mon_on = 1'b0;
    bit in_low = 1'b0, in_high = 1'b0;
    int lo_n, hi_n, last_tick, s_off, s_cnt, d_cnt, tick_lo;
    bit d_first;

    task automatic close_bit();
        exp_t e;
        in_high = 1'b0;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected bit", 1, 0);
        end else begin
            e = exp_q.pop_front();
            chk(lo_n == e.lo, e.lreq, lo_n, e.lo);
            chk(last_tick == e.hi, e.hreq, last_tick, e.hi);
            chk(s_off == e.so, "R7 offset", s_off, e.so);
            chk(s_cnt == 1, "R7 count", s_cnt, 1);
            chk(d_cnt == 1, "R6 count", d_cnt, 1);
            chk(d_first, "R6 first low cycle", int'(d_first), 1);
            chk(tick_lo == e.nt, "R2 ticks in low", tick_lo, e.nt);
            if (e.refp != 0)
                chk(lo_n + last_tick == e.refp, "R10 period", lo_n + last_tick, e.refp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (!scl_o) begin
                if (in_high) close_bit();
                if (!in_low) begin
                    in_low  = 1'b1;
                    lo_n    = 0;
                    d_cnt   = 0;
                    tick_lo = 0;
                    d_first = drive_stb;
                end
                lo_n++;
                if (drive_stb) d_cnt++;
                if (samp_tick) tick_lo++;
            end else begin
                if (in_low) begin
                    in_low    = 1'b0;
                    in_high   = 1'b1;
                    hi_n      = 0;
                    last_tick = 0;
                    s_off     = -1;
                    s_cnt     = 0;
                end
                if (in_high) begin
                    hi_n++;
                    if (samp_tick) last_tick = hi_n;
                    if (sample_stb) begin
                        s_cnt++;
                        s_off = hi_n - 1;
                    end
                    if (hi_n - last_tick > 600) close_bit();
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int ticks;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(scl_o == 1'b1, "R1 reset scl", int'(scl_o), 1);
        chk({samp_tick, drive_stb, sample_stb} == 3'b000, "R1 reset strobes",
            int'({samp_tick, drive_stb, sample_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        // R2: idle produces no ticks
        ticks = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (samp_tick || !scl_o) ticks++;
        end
        chk(ticks == 0, "R2 idle quiet", ticks, 0);
        mon_on = 1'b1;

        // R10 / R3 / R4 reference rates
        one_bit(1, 111, 117, 1'b0, 480);
        one_bit(1, 23, 25, 1'b0, 120);
        one_bit(1, 5, 7, 1'b0, 48);
        one_bit(23, 13, 15, 1'b0, 960);
        one_bit(9, 5, 7, 1'b0, 240);
        one_bit(0, 0, 0, 1'b0, 12);

        // R5: high-speed byte lanes vs standard lanes of the same words
        one_bit(0, 16'h0A03, 16'h0602, 1'b1, 0);
        one_bit(0, 16'h0A03, 16'h0602, 1'b0, 0);
        one_bit(2, 16'h0401, 16'h0309, 1'b1, 0);

        // R8 / R9: three-bit burst with a reprogram mid-burst (T = 57 clocks)
        @(negedge clk);
        psc_val = 8'd2; scll_word = 16'd3; sclh_word = 16'd4; hs_sel = 1'b0;
        run = 1'b1;
        for (int b = 0; b < 3; b++) push_exp(2, 3, 4, 0, "R9", "R9");
        repeat (28) @(negedge clk);
        scll_word = 16'd50; sclh_word = 16'd40; psc_val = 8'd5;
        repeat (57 * 2 + 28 - 28) @(negedge clk);
        run = 1'b0;
        repeat (57 + 700) @(negedge clk);
        chk(exp_q.size() == 0, "R8 burst length", exp_q.size(), 0);
        // R9: new values take effect at the next start
        one_bit(5, 50, 40, 1'b0, 0);

        // R1: disable in the middle of a bit
        mon_on = 1'b0;
        @(negedge clk);
        psc_val = 8'd3; scll_word = 16'd20; sclh_word = 16'd20; run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        repeat (30) @(negedge clk);
        chk(scl_o == 1'b0, "R1 mid-bit low before disable", int'(scl_o), 0);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1, "R1 released on disable", int'(scl_o), 1);
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (samp_tick || drive_stb || sample_stb || !scl_o) ticks++;
        end
        chk(ticks == 0, "R1 quiet while disabled", ticks, 0);
        enable = 1'b1;
        in_low = 1'b0;
        in_high = 1'b0;
        mon_on = 1'b1;
        one_bit(3, 20, 20, 1'b0, 0);

        chk(exp_q.size() == 0, "R8 all bits seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule